// File: doc/BRIEF.md
# Undefined-Length Incrementing Burst Manager

This block is the bus-side engine of a simple data mover. It takes one command at a time: a start address, a beat size, a direction and a total beat count. It then drives the transfer onto a single-layer AHB-Lite style bus as incrementing bursts that never state their length. The subordinate learns where a burst ends only from the transfer type seen in the next address phase. A burst opens with NONSEQ and continues with SEQ. It ends when the manager drives IDLE, or a fresh NONSEQ, in the address phase after the last beat it wants.

A long transfer is cut into bursts of at most `MAX_BURST` beats. Between two capped bursts the manager spends one address slot on IDLE, which lets an arbiter regrant the bus. A 100-word copy therefore goes out as one continuous stream of capped bursts, with no stray single transfers at the end. A burst is also restarted with NONSEQ before it would step onto a 1 KB address boundary. Write data comes from a valid/ready source, one word per beat. If the source has no word ready when a beat is due, that slot carries IDLE and the stream resumes later with NONSEQ. A one-cycle `done` pulse marks the end of the command.

Top module: `incr_stream_mgr`

## Requirements
- R1: The first beat of every burst is driven with transfer type NONSEQ (2'b10), and each later beat of the same burst with SEQ (2'b11). A SEQ beat only ever follows directly after an active beat in the previous address slot.
- R2: Beat i of a command is driven at address start + i * 2^size. `hsize` equals the commanded size, `hburst` is held at 3'b001 (incrementing, length not stated), and `hwrite` equals the commanded direction.
- R3: No burst holds more than `MAX_BURST` beats. When a burst reaches the cap and beats remain, the next accepted address slot is IDLE (2'b00), and the beat after it opens with NONSEQ.
- R4: Any beat whose address has its low 10 bits all zero is driven as NONSEQ.
- R5: While `hready` is low, `htrans`, `haddr` and `hwdata` hold their values, and no beat is consumed.
- R6: For a write, a beat is issued only in a slot where `wr_valid` is high. Exactly one word is taken per beat, in order, and the data phase of beat i carries the i-th word. A slot with no word available carries IDLE.
- R7: For a read, `wr_ready` stays low and `hwrite` is 0.
- R8: `done` is high for one cycle, in the cycle after the data phase of the final beat completes with `hready` high. A command with zero beats raises `done` in the cycle after it is accepted and drives no active transfer.
- R9: `cmd_ready` is high only while no beats remain to issue and no beat sits in an address or data phase. A command is accepted only then.
- R10: After reset, `htrans` is IDLE, `done` is 0, `cmd_ready` is 1 and `wr_ready` is 0.
- R11: A command with no boundary crossing and no data starvation produces exactly ceil(beats / `MAX_BURST`) bursts, counted as NONSEQ beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Manager idle, command taken when valid |
| cmd_addr | input | AW | Byte address of the first beat |
| cmd_size | input | 3 | Beat size as log2 of bytes |
| cmd_beats | input | CW | Total number of beats (0 allowed) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| wr_valid | input | 1 | Write word available |
| wr_ready | output | 1 | Write word taken at this edge |
| wr_data | input | DW | Write word |
| htrans | output | 2 | Bus transfer type |
| haddr | output | AW | Bus address |
| hburst | output | 3 | Burst type, fixed at undefined-length incrementing |
| hsize | output | 3 | Bus beat size |
| hwrite | output | 1 | Bus direction |
| hwdata | output | DW | Bus write data (data phase) |
| hready | input | 1 | Bus ready; low stretches the current phase |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is when several break causes land close together in one stream: a capped burst, a 1 KB crossing and a starved write source. Each one changes whether the next beat is SEQ, NONSEQ or preceded by IDLE. The stimulus reaches this with start addresses placed a few beats below a 1 KB boundary and a small burst cap. It adds an `hready` pattern that stalls every third cycle and a write source that drops out every fifth cycle. The bench then predicts each accepted slot's type, address and data-phase word from the beat index, the run length so far and whether the previous accepted slot was idle.

// File: rtl/incr_stream_pkg.sv
package incr_stream_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] BURST_OPEN_INCR = 3'b001;

    localparam int BOUNDARY_LOG2 = 10;

    function automatic logic trans_active(input logic [1:0] t);
        return t[1];
    endfunction

endpackage

// File: rtl/incr_addr_step.sv
module incr_addr_step #(
    parameter int AW  = 32,
    parameter int BND = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [2:0]    size,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic          at_bound
);
    logic [AW-1:0] stride;

    always_comb begin
        stride   = AW'(1) << size;
        at_bound = (cur_addr[BND-1:0] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
        end else if (step) begin
            cur_addr <= cur_addr + stride;
        end
    end
endmodule

// File: rtl/incr_beat_sched.sv
module incr_beat_sched #(
    parameter int CW   = 16,
    parameter int MAXB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_beats,
    input  logic          slot_open,
    input  logic          prev_active,
    input  logic          data_ok,
    input  logic          at_bound,
    output logic          issue,
    output logic          seq,
    output logic          gap,
    output logic          more,
    output logic          last,
    output logic          pull
);
    localparam int KW = $clog2(MAXB + 1);

    logic [CW-1:0] rem;
    logic [KW-1:0] run;

    always_comb begin
        more  = (rem != '0);
        last  = (rem == CW'(1));
        gap   = prev_active && (run == KW'(MAXB));
        pull  = slot_open && more && !gap;
        issue = pull && data_ok;
        seq   = prev_active && !at_bound;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            run <= '0;
        end else if (load) begin
            rem <= load_beats;
            run <= '0;
        end else if (issue) begin
            rem <= rem - CW'(1);
            run <= seq ? run + KW'(1) : KW'(1);
        end
    end
endmodule

// File: rtl/incr_data_phase.sv
module incr_data_phase #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_open,
    input  logic          addr_active,
    input  logic          addr_last,
    input  logic          capture,
    input  logic [DW-1:0] cap_data,
    input  logic          zero_done,
    output logic [DW-1:0] hwdata,
    output logic          dp_busy,
    output logic          done
);
    logic [DW-1:0] held;
    logic          dp_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            hwdata  <= '0;
            dp_busy <= 1'b0;
            dp_last <= 1'b0;
            done    <= 1'b0;
        end else begin
            if (capture) held <= cap_data;
            if (slot_open) begin
                dp_busy <= addr_active;
                dp_last <= addr_last;
                if (addr_active) hwdata <= held;
            end
            done <= (slot_open && dp_busy && dp_last) || zero_done;
        end
    end
endmodule

// File: rtl/incr_stream_mgr.sv
module incr_stream_mgr
    import incr_stream_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 16,
    parameter int MAX_BURST = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic [2:0]    cmd_size,
    input  logic [CW-1:0] cmd_beats,
    input  logic          cmd_write,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_data,
    output logic [1:0]    htrans,
    output logic [AW-1:0] haddr,
    output logic [2:0]    hburst,
    output logic [2:0]    hsize,
    output logic          hwrite,
    output logic [DW-1:0] hwdata,
    input  logic          hready,
    output logic          done
);
    trans_e        htrans_q;
    logic [AW-1:0] haddr_q;
    logic [2:0]    size_q;
    logic          wr_q;
    logic          last_q;

    logic [AW-1:0] cur_addr;
    logic          at_bound;
    logic          issue, seq, gap, more, last, pull;
    logic          dp_busy;
    logic          cmd_fire;
    logic          prev_active;
    logic          data_ok;

    always_comb begin
        prev_active = trans_active(htrans_q);
        data_ok     = !wr_q || wr_valid;
        cmd_ready   = !(more || prev_active || dp_busy);
        cmd_fire    = cmd_valid && cmd_ready;
        wr_ready    = pull && wr_q;
        htrans      = htrans_q;
        haddr       = haddr_q;
        hburst      = BURST_OPEN_INCR;
        hsize       = size_q;
        hwrite      = wr_q;
    end

    incr_addr_step #(.AW(AW), .BND(BOUNDARY_LOG2)) u_addr (
        .clk(clk), .rst(rst), .load(cmd_fire), .load_addr(cmd_addr),
        .size(size_q), .step(issue), .cur_addr(cur_addr), .at_bound(at_bound)
    );

    incr_beat_sched #(.CW(CW), .MAXB(MAX_BURST)) u_sched (
        .clk(clk), .rst(rst), .load(cmd_fire), .load_beats(cmd_beats),
        .slot_open(hready), .prev_active(prev_active), .data_ok(data_ok),
        .at_bound(at_bound), .issue(issue), .seq(seq), .gap(gap),
        .more(more), .last(last), .pull(pull)
    );

    incr_data_phase #(.DW(DW)) u_dphase (
        .clk(clk), .rst(rst), .slot_open(hready), .addr_active(prev_active),
        .addr_last(last_q), .capture(issue && wr_q), .cap_data(wr_data),
        .zero_done(cmd_fire && (cmd_beats == '0)), .hwdata(hwdata),
        .dp_busy(dp_busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            htrans_q <= TR_IDLE;
            haddr_q  <= '0;
            size_q   <= '0;
            wr_q     <= 1'b0;
            last_q   <= 1'b0;
        end else begin
            if (cmd_fire) begin
                size_q <= cmd_size;
                wr_q   <= cmd_write;
            end
            if (hready) begin
                htrans_q <= issue ? (seq ? TR_SEQ : TR_NONSEQ) : TR_IDLE;
                if (issue) haddr_q <= cur_addr;
                last_q <= issue && last;
            end
        end
    end
endmodule

// File: rtl/incr_stream_mgr_chk.sv
module incr_stream_mgr_chk #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int MAXB = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    htrans,
    input logic [AW-1:0] haddr,
    input logic [2:0]    hsize,
    input logic          hwrite,
    input logic [DW-1:0] hwdata,
    input logic          hready,
    input logic          wr_ready,
    input logic          cmd_ready,
    input logic          done
);
    localparam int LW = $clog2(MAXB + 1) + 1;

    logic [LW-1:0] blen;

    always_ff @(posedge clk) begin
        if (rst) blen <= '0;
        else if (hready && htrans[1]) blen <= (htrans == 2'b10) ? LW'(1) : blen + LW'(1);
    end

    assert_seq_follows_active_R1: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b11) |-> $past(htrans[1]));

    assert_addr_steps_R2: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'b11 && $past(hready) && !$past(rst)) |-> (haddr == $past(haddr) + (AW'(1) << hsize)));

    assert_burst_capped_R3: assert property (@(posedge clk) disable iff (rst)
        (hready && htrans == 2'b11) |-> (blen < LW'(MAXB)));

    assert_boundary_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (htrans[1] && haddr[9:0] == 10'd0) |-> (htrans == 2'b10));

    assert_hold_on_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hready)) |-> ($stable(htrans) && $stable(haddr) && $stable(hwdata)));

    assert_read_no_pull_R7: assert property (@(posedge clk) disable iff (rst)
        !hwrite |-> !wr_ready);

    assert_done_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);  // also R9
endmodule

bind incr_stream_mgr incr_stream_mgr_chk #(.AW(AW), .DW(DW), .MAXB(MAX_BURST)) u_chk (.*);

// File: tb/incr_stream_mgr_tb.sv
`timescale 1ns/1ps
module incr_stream_mgr_tb;
    localparam int MAXB = 4;
    localparam logic [31:0] DBASE = 32'hA000_0000;
    // {addr[60:29], size[28:26], beats[25:10], write[9], stall[8], nonseq_count[7:0]}
    localparam logic [60:0] VECS [0:7] = '{
        {32'h0000_1000, 3'd2, 16'd10,  1'b1, 1'b0, 8'd3},
        {32'h0000_2000, 3'd2, 16'd4,   1'b0, 1'b0, 8'd1},
        {32'h0000_03F8, 3'd2, 16'd6,   1'b1, 1'b1, 8'd2},
        {32'h0000_0100, 3'd0, 16'd9,   1'b1, 1'b1, 8'd3},
        {32'h0000_03FA, 3'd1, 16'd5,   1'b0, 1'b1, 8'd2},
        {32'h0000_0000, 3'd2, 16'd1,   1'b1, 1'b0, 8'd1},
        {32'h0000_5000, 3'd2, 16'd100, 1'b1, 1'b1, 8'd25},
        {32'h0000_07F4, 3'd2, 16'd8,   1'b0, 1'b0, 8'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [2:0]  cmd_size = '0;
    logic [15:0] cmd_beats = '0;
    logic wr_valid = 1'b0, wr_ready;
    logic [31:0] wr_data = '0;
    logic [1:0]  htrans;
    logic [31:0] haddr, hwdata;
    logic [2:0]  hburst, hsize;
    logic hwrite, done;
    logic hready = 1'b1;

    int checks = 0, fails = 0;
    int cyc = 0;
    logic mon_on = 1'b0, hr_mode = 1'b0, wv_mode = 1'b0;
    logic [31:0] cur_addr; logic [2:0] cur_size; int cur_beats; logic cur_write;
    int beat_idx, src_idx, blen, ns_cnt, dp_idx;
    logic prev_idle, gap_due, dp_pend, exp_done, bad_rd;

    always #2.5 clk = ~clk;

    incr_stream_mgr #(.AW(32), .DW(32), .CW(16), .MAX_BURST(MAXB)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_beats(cmd_beats),
        .cmd_write(cmd_write), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .htrans(htrans), .haddr(haddr), .hburst(hburst),
        .hsize(hsize), .hwrite(hwrite), .hwdata(hwdata), .hready(hready), .done(done)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // bus subordinate model and monitor
    initial begin
        exp_done = 1'b0;
        forever begin
            logic [31:0] exp_addr;
            logic        exp_ns;
            @(negedge clk);
            cyc++;
            hready   = hr_mode ? (cyc % 3 != 1) : 1'b1;
            wr_valid = wv_mode ? (cyc % 5 != 2) : 1'b1;
            wr_data  = DBASE + 32'(src_idx);
            #1;
            if (mon_on) begin
                if (done || exp_done) chk(done == exp_done, "R8 done timing", {31'd0, done}, {31'd0, exp_done});
                exp_done = 1'b0;
                if (!cur_write && wr_ready) bad_rd = 1'b1;
                if (wr_valid && wr_ready) src_idx++;
                if (hready) begin
                    if (dp_pend) begin
                        if (cur_write) chk(hwdata == DBASE + 32'(dp_idx), "R6 data-phase word", hwdata, DBASE + 32'(dp_idx));
                        if (dp_idx == cur_beats - 1) exp_done = 1'b1;
                    end
                    dp_pend = 1'b0;
                    if (gap_due) begin
                        chk(htrans == 2'b00, "R3 idle slot after capped burst", {30'd0, htrans}, 32'd0);
                        gap_due = 1'b0;
                    end
                    if (htrans[1]) begin
                        exp_addr = cur_addr + (32'(beat_idx) << cur_size);
                        exp_ns = (beat_idx == 0) || prev_idle || (blen == MAXB) || (exp_addr[9:0] == 10'd0);
                        chk(haddr == exp_addr, "R2 beat address", haddr, exp_addr);
                        chk(htrans == (exp_ns ? 2'b10 : 2'b11), "R1/R4 transfer type", {30'd0, htrans}, exp_ns ? 32'd2 : 32'd3);
                        chk(hburst == 3'b001 && hsize == cur_size && hwrite == cur_write, "R2 control fields",
                            {25'd0, hburst, hsize, hwrite}, {25'd0, 3'b001, cur_size, cur_write});
                        blen = exp_ns ? 1 : blen + 1;
                        if (exp_ns) ns_cnt++;
                        if (blen == MAXB && beat_idx + 1 < cur_beats) gap_due = 1'b1;
                        dp_pend = 1'b1;
                        dp_idx = beat_idx;
                        beat_idx++;
                        prev_idle = 1'b0;
                    end else begin
                        prev_idle = 1'b1;
                    end
                end
            end
        end
    end

    task automatic run_cmd(input logic [31:0] a, input logic [2:0] s, input logic [15:0] n,
                           input logic w, input logic hrm, input logic wvm, input int exp_ns);
        cur_addr = a; cur_size = s; cur_beats = int'(n); cur_write = w;
        beat_idx = 0; src_idx = 0; blen = 0; ns_cnt = 0; dp_idx = 0;
        prev_idle = 1'b1; gap_due = 1'b0; dp_pend = 1'b0; bad_rd = 1'b0;
        hr_mode = hrm; wv_mode = wvm;
        @(negedge clk);
        cmd_addr = a; cmd_size = s; cmd_beats = n; cmd_write = w; cmd_valid = 1'b1;
        #2;
        while (!cmd_ready) begin @(negedge clk); #2; end
        @(negedge clk);
        cmd_valid = 1'b0;
        if (n == 16'd0) exp_done = 1'b1;
        #2;
        chk(cmd_ready == (n == 16'd0), "R9 busy after accept", {31'd0, cmd_ready}, {31'd0, n == 16'd0});
        while (!done) begin @(negedge clk); #2; end
        chk(cmd_ready == 1'b1, "R9 idle at done", {31'd0, cmd_ready}, 32'd1);
        chk(beat_idx == cur_beats, "R8 all beats before done", 32'(beat_idx), 32'(cur_beats));
        if (exp_ns >= 0) chk(ns_cnt == exp_ns, "R11 burst count", 32'(ns_cnt), 32'(exp_ns));
        if (!w) chk(!bad_rd, "R7 no write pull on read", {31'd0, bad_rd}, 32'd0);
        hr_mode = 1'b0; wv_mode = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        chk(htrans == 2'b00, "R10 reset htrans", {30'd0, htrans}, 32'd0);
        chk(done == 1'b0, "R10 reset done", {31'd0, done}, 32'd0);
        chk(cmd_ready == 1'b1, "R10 reset cmd_ready", {31'd0, cmd_ready}, 32'd1);
        chk(wr_ready == 1'b0, "R10 reset wr_ready", {31'd0, wr_ready}, 32'd0);
        mon_on = 1'b1;

        for (int k = 0; k < 8; k++) begin
            logic [60:0] v;
            v = VECS[k];
            run_cmd(v[60:29], v[28:26], v[25:10], v[9], v[8], 1'b0, int'(v[7:0]));
        end

        // R8: zero-beat command completes without bus activity
        run_cmd(32'h0000_3000, 3'd2, 16'd0, 1'b1, 1'b0, 1'b0, 0);
        // R6: starving write source with stalls, crossing a 1 KB boundary
        run_cmd(32'h0000_0BF0, 3'd2, 16'd12, 1'b1, 1'b1, 1'b1, -1);
        // R5/R3: single-byte beats under stalls, exact multiple of the cap
        run_cmd(32'h0000_0200, 3'd0, 16'd8, 1'b0, 1'b1, 1'b0, 2);

        summary();
        $finish;
    end
endmodule